// File: doc/BRIEF.md
# Pulse-Interval Command Decoder with Frame Buffer

This block turns the demodulated reader envelope into command bits. A clock enable samples the envelope at a fixed low rate, nominally 160 kHz. The decoder times the interval between consecutive falling edges and decides each bit against a threshold, which is half the combined length of a zero symbol and a one symbol. An optional preamble lets the decoder calibrate that threshold. Without a preamble it uses a fixed default of 3 samples. At a nominal 12.5 µs Tari and 160 kHz, a zero symbol spans 2 samples and a one symbol spans 4 samples.

Decoded bits fill a six-word, 32-bit frame buffer. The host reads that buffer through a simple combinational read port. Word 0 takes a protocol/tag-number header value supplied by the host side when the command completes. Words 1 to 5 take up to 160 command bits. A long quiet gap ends a command. The block then pulses an interrupt for one clock and holds the frame untouched until the host acknowledges it.

Top module: `pie_cmd_decoder`

## Requirements
- R1: After reset `irq` is low and every read address, 0 through 7, returns zero.
- R2: A symbol ends at every sampled falling edge of the envelope. Its length is the number of sample ticks since the previous falling edge. A length strictly greater than the threshold decodes as 1, and a length equal to or below it decodes as 0.
- R3: A command starts at a falling edge seen while idle. If the first low phase lasts fewer than `DELIM_MIN` (2) samples, there is no preamble. The threshold is then 3, and the interval from that edge to the next falling edge is the first data symbol.
- R4: A first low phase of at least `DELIM_MIN` samples is a delimiter. The next interval, counted from the rising edge plus one sample, is the reference zero. The interval after it is a calibration interval spanning one zero plus one one. The threshold becomes floor(calibration / 2).
- R5: If the calibration interval is not longer than the reference zero, the threshold falls back to 3.
- R6: Decoded bit k lands in word 1 + k/32 at bit position 31 - (k mod 32), so the first bit goes to the MSB of word 1. Bits not written read as 0. Addresses 6 and 7 read as 0.
- R7: Only the first 160 bits are stored. Later bits are dropped, and stored words are left unchanged.
- R8: A command ends once no falling edge has arrived for more than 2·`MAX_SYM` (16) samples. At that point word 0 captures `hdr_in` as it is in that cycle.
- R9: At command completion `irq` is high for exactly one clock.
- R10: After completion, the buffer is frozen until `host_ack`. Envelope activity in this period changes no word and raises no interrupt.
- R11: After an acknowledge, the next command clears all data words before filling them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| env_in | input | 1 | Demodulated envelope (high = carrier) |
| hdr_in | input | 32 | Protocol/tag header value, captured into word 0 at completion |
| rd_addr | input | 3 | Frame word select |
| rd_data | output | 32 | Selected frame word |
| host_ack | input | 1 | Host has read the frame; releases the buffer |
| irq | output | 1 | One-clock completion pulse |

## Verification
The bench sends symbols whose lengths sit exactly on the threshold, for example 3 samples without a preamble and 4 samples after a 9-sample calibration. A decoder using greater-or-equal, or ignoring the calibration, flips those bits. A preamble whose calibration is not longer than its reference must revert to the default threshold, and an odd calibration must round down. A 161-bit command checks that the extra bit neither wraps into word 1 nor corrupts word 5. A second command sent before the acknowledge must leave the frame and the interrupt untouched, and the command after the acknowledge must not inherit stale bits. The bench also changes the header late in a command and bounds the interrupt arrival time, which catches early capture and a wrong gap limit.

// File: rtl/pie_pkg.sv
package pie_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_REF,
        S_CAL,
        S_DATA,
        S_DONE
    } dec_state_e;

endpackage

// File: rtl/pie_sample_tick.sv
module pie_sample_tick #(
    parameter int CLK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == DIV_W'(CLK_DIV - 1));
        cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pie_env_sampler.sv
module pie_env_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic env_in,
    output logic fall,
    output logic rise
);
    logic [1:0] sync_d, sync_q;
    logic       lvl_d, lvl_q;

    always_comb begin
        sync_d = {sync_q[0], env_in};
        lvl_d  = tick ? sync_q[1] : lvl_q;
        fall   = tick &  lvl_q & ~sync_q[1];
        rise   = tick & ~lvl_q &  sync_q[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            lvl_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            lvl_q  <= lvl_d;
        end
    end
endmodule

// File: rtl/pie_frame_store.sv
module pie_frame_store #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 6,
    parameter int ADDR_W = $clog2(WORDS),
    parameter int BIT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [BIT_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              hdr_en,
    input  logic [WORD_W-1:0] hdr_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DATA_BITS = (WORDS - 1) * WORD_W;

    logic [DATA_BITS-1:0] bits_d, bits_q;
    logic [WORD_W-1:0]    hdr_d, hdr_q;
    logic [WORD_W-1:0]    word_arr [WORDS];

    always_comb begin
        bits_d = bits_q;
        hdr_d  = hdr_q;
        if (clr) bits_d = '0;
        if (wr_en) begin
            for (int k = 0; k < DATA_BITS; k++) begin
                if (wr_idx == BIT_W'(k)) bits_d[DATA_BITS-1-k] = wr_bit;
            end
        end
        if (hdr_en) hdr_d = hdr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            hdr_q  <= '0;
        end else begin
            bits_q <= bits_d;
            hdr_q  <= hdr_d;
        end
    end

    assign word_arr[0] = hdr_q;
    for (genvar w = 1; w < WORDS; w++) begin : g_word
        assign word_arr[w] = bits_q[DATA_BITS-1-(w-1)*WORD_W -: WORD_W];
    end

    always_comb begin
        if (int'(rd_addr) < WORDS) rd_data = word_arr[rd_addr];
        else                       rd_data = '0;
    end
endmodule

// File: rtl/pie_cmd_decoder.sv
module pie_cmd_decoder
    import pie_pkg::*;
#(
    parameter int CLK_DIV   = 100,
    parameter int WORD_W    = 32,
    parameter int WORDS     = 6,
    parameter int ADDR_W    = $clog2(WORDS),
    parameter int MAX_SYM   = 8,
    parameter int DELIM_MIN = 2,
    parameter int DEF_THR   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              env_in,
    input  logic [WORD_W-1:0] hdr_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              host_ack,
    output logic              irq
);
    localparam int DATA_BITS = (WORDS - 1) * WORD_W;
    localparam int BIT_W     = $clog2(DATA_BITS + 1);
    localparam int GAP_LIM   = 2 * MAX_SYM;
    localparam int CNT_W     = $clog2(GAP_LIM + 2);

    typedef struct packed {
        dec_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
        logic [CNT_W-1:0] ref_len;
        logic [BIT_W-1:0] nbits;
        logic             irq;
    } ctl_t;

    ctl_t r_d, r_q;

    logic tick, fall, rise;
    logic clr, wr_en, wr_bit, hdr_en, finish, tmo;
    logic [CNT_W-1:0] len;

    dec_state_e       state_w;
    logic [BIT_W-1:0] nbits_w;
    logic [CNT_W-1:0] thr_w;

    pie_sample_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    pie_env_sampler u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .env_in(env_in),
        .fall  (fall),
        .rise  (rise)
    );

    pie_frame_store #(
        .WORD_W(WORD_W),
        .WORDS (WORDS),
        .ADDR_W(ADDR_W),
        .BIT_W (BIT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_idx (r_q.nbits),
        .wr_bit (wr_bit),
        .hdr_en (hdr_en),
        .hdr_in (hdr_in),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        clr     = 1'b0;
        wr_en   = 1'b0;
        wr_bit  = 1'b0;
        hdr_en  = 1'b0;
        finish  = 1'b0;
        len     = r_q.cnt + CNT_W'(1);
        tmo     = (r_q.cnt >= CNT_W'(GAP_LIM));

        unique case (r_q.state)
            S_IDLE: begin
                if (fall) begin
                    r_d.state   = S_START;
                    r_d.cnt     = '0;
                    r_d.thr     = CNT_W'(DEF_THR);
                    r_d.ref_len = '0;
                    r_d.nbits   = '0;
                    clr         = 1'b1;
                end
            end
            S_START: begin
                if (rise) begin
                    if (len >= CNT_W'(DELIM_MIN)) begin
                        r_d.state = S_REF;
                        r_d.cnt   = CNT_W'(1);
                    end else begin
                        r_d.state = S_DATA;
                        r_d.cnt   = len;
                    end
                end else if (tick) begin
                    if (tmo) finish = 1'b1;
                    else     r_d.cnt = len;
                end
            end
            S_REF: begin
                if (fall) begin
                    r_d.ref_len = len;
                    r_d.state   = S_CAL;
                    r_d.cnt     = '0;
                end else if (tick) begin
                    if (tmo) finish = 1'b1;
                    else     r_d.cnt = len;
                end
            end
            S_CAL: begin
                if (fall) begin
                    r_d.thr   = (len > r_q.ref_len) ? (len >> 1) : CNT_W'(DEF_THR);
                    r_d.state = S_DATA;
                    r_d.cnt   = '0;
                end else if (tick) begin
                    if (tmo) finish = 1'b1;
                    else     r_d.cnt = len;
                end
            end
            S_DATA: begin
                if (fall) begin
                    if (r_q.nbits < BIT_W'(DATA_BITS)) begin
                        wr_en     = 1'b1;
                        wr_bit    = (len > r_q.thr);
                        r_d.nbits = r_q.nbits + BIT_W'(1);
                    end
                    r_d.cnt = '0;
                end else if (tick) begin
                    if (tmo) finish = 1'b1;
                    else     r_d.cnt = len;
                end
            end
            S_DONE: begin
                if (host_ack) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase

        if (finish) begin
            r_d.state = S_DONE;
            r_d.irq   = 1'b1;
            hdr_en    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= S_IDLE;
            r_q.cnt     <= '0;
            r_q.thr     <= CNT_W'(DEF_THR);
            r_q.ref_len <= '0;
            r_q.nbits   <= '0;
            r_q.irq     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq     = r_q.irq;
    assign state_w = r_q.state;
    assign nbits_w = r_q.nbits;
    assign thr_w   = r_q.thr;
endmodule

// File: rtl/pie_cmd_decoder_chk.sv
module pie_cmd_decoder_chk
    import pie_pkg::*;
#(
    parameter int BIT_W     = 8,
    parameter int CNT_W     = 5,
    parameter int DATA_BITS = 160
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             irq,
    input logic             host_ack,
    input dec_state_e       state,
    input logic [BIT_W-1:0] nbits,
    input logic [CNT_W-1:0] thr
);
    // R9: completion pulse lasts one clock
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: the pulse only accompanies a finished frame
    assert_irq_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state == S_DONE));

    // R10: frame stays frozen until the host acknowledges
    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !host_ack) |=> (state == S_DONE && $stable(nbits)));

    // R2: bit count moves only on a sample tick
    assert_bits_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(nbits));

    // R7: never more bits than the data words hold
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= BIT_W'(DATA_BITS));

    // R4: a calibrated threshold is never zero
    assert_thr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> (thr != '0));
endmodule

bind pie_cmd_decoder pie_cmd_decoder_chk #(
    .BIT_W    (BIT_W),
    .CNT_W    (CNT_W),
    .DATA_BITS(DATA_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .irq     (irq),
    .host_ack(host_ack),
    .state   (state_w),
    .nbits   (nbits_w),
    .thr     (thr_w)
);

// File: tb/sim_pie_cmd_decoder.sv
module sim_pie_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        env_in;
    logic [31:0] hdr_in;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        host_ack;
    logic        irq;

    pie_cmd_decoder #(.CLK_DIV(DIV)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .env_in  (env_in),
        .hdr_in  (hdr_in),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .host_ack(host_ack),
        .irq     (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int lens [0:199];
    int nsym;
    logic [159:0] expv;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic lvl);
        @(negedge clk) env_in = lvl;
        repeat (DIV - 1) @(negedge clk);
    endtask

    task automatic sym(input int len);
        repeat (len - 1) put(1'b1);
        put(1'b0);
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk) rd_addr = 3'(a);
        #1 d = rd_data;
    endtask

    task automatic ack();
        @(negedge clk) host_ack = 1'b1;
        @(negedge clk) host_ack = 1'b0;
    endtask

    // send a command and build the expected bit image from the requirements
    task automatic send(input bit pre, input int ref_l, input int cal_l);
        int thr;
        repeat (3) put(1'b1);
        if (pre) begin
            put(1'b0); put(1'b0);
            sym(ref_l);
            sym(cal_l);
        end else begin
            put(1'b0);
        end
        for (int k = 0; k < nsym; k++) sym(lens[k]);
        put(1'b1);
        thr  = (pre && cal_l > ref_l) ? cal_l / 2 : 3;
        expv = '0;
        for (int k = 0; k < nsym && k < 160; k++) expv[159-k] = (lens[k] > thr);
    endtask

    task automatic wait_irq(input string tag, input bit check_time);
        bit got = 0;
        int cyc = 0;
        for (int i = 0; i < 500 && !got; i++) begin
            @(negedge clk);
            cyc++;
            if (irq) begin
                got = 1;
                @(negedge clk);
                chk({tag, " R9 irq width"}, {31'd0, irq}, 32'd0);
            end
        end
        chk({tag, " R9 irq seen"}, {31'd0, got}, 32'd1);
        if (check_time)
            chk({tag, " R8 gap timing"}, {31'd0, (cyc >= 26 && cyc <= 50)}, 32'd1);
    endtask

    task automatic check_frame(input string tag, input logic [31:0] hdr);
        logic [31:0] d;
        rd(0, d);
        chk({tag, " R8 word0"}, d, hdr);
        for (int w = 1; w < 6; w++) begin
            rd(w, d);
            chk($sformatf("%s R6 word%0d", tag, w), d, expv[159-(w-1)*32 -: 32]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk($sformatf("R1 reset addr%0d", a), d, 32'd0);
        end
    endtask

    // R2 R3 R8: no preamble, default threshold, late header capture
    task automatic t_plain();
        int l[10] = '{2, 4, 3, 4, 2, 2, 4, 3, 4, 4};
        nsym = 10;
        for (int k = 0; k < 10; k++) lens[k] = l[k];
        hdr_in = 32'h0C00_0105;
        send(0, 0, 0);
        hdr_in = 32'hB000_0A11;
        wait_irq("plain", 1);
        check_frame("plain R3", 32'hB000_0A11);
        ack();
    endtask

    // R4: calibrated threshold, including an odd calibration
    task automatic t_pre();
        int l[8] = '{3, 6, 4, 5, 4, 6, 3, 5};
        nsym = 8;
        for (int k = 0; k < 8; k++) lens[k] = l[k];
        hdr_in = 32'h0000_00C4;
        send(1, 3, 9);
        wait_irq("pre9", 0);
        check_frame("pre9 R4", 32'h0000_00C4);
        ack();
        nsym = 2; lens[0] = 3; lens[1] = 4;
        send(1, 2, 7);
        wait_irq("pre7", 0);
        check_frame("pre7 R4", 32'h0000_00C4);
        ack();
    endtask

    // R5 then R10 then R11
    task automatic t_bad_freeze_clear();
        logic [159:0] held;
        bit stray = 0;
        nsym = 4; lens[0] = 4; lens[1] = 3; lens[2] = 2; lens[3] = 4;
        hdr_in = 32'h5A00_0002;
        send(1, 4, 4);
        wait_irq("badpre", 0);
        check_frame("badpre R5", 32'h5A00_0002);
        held = expv;
        nsym = 3; lens[0] = 2; lens[1] = 2; lens[2] = 2;
        send(0, 0, 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq) stray = 1;
        end
        chk("R10 no irq while frozen", {31'd0, stray}, 32'd0);
        expv = held;
        check_frame("frozen R10", 32'h5A00_0002);
        ack();
        nsym = 1; lens[0] = 4;
        send(0, 0, 0);
        wait_irq("clear", 0);
        check_frame("clear R11", 32'h5A00_0002);
        ack();
    endtask

    // R6 R7: fill all data words and drop bit 161
    task automatic t_cap();
        nsym = 161;
        for (int k = 0; k < 161; k++) lens[k] = (k % 3 == 1) ? 4 : 2;
        hdr_in = 32'hFFFF_0000;
        send(0, 0, 0);
        wait_irq("cap", 0);
        check_frame("cap R7", 32'hFFFF_0000);
        ack();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; env_in = 1'b1; hdr_in = '0; rd_addr = '0; host_ack = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_pre();
        t_bad_freeze_clear();
        t_cap();
        summary();
        $finish;
    end
endmodule